// File: doc/BRIEF.md
# Hot-plug slot control and notification

This block keeps the slot control and slot status state of a downstream or root port that supports hot-plug. It records the slot events (attention button, power fault, presence change, command completed), the presence state and an electromechanical interlock. It also raises a notification whenever the combined event level changes. Configuration software writes the block through a select/data/byte-enable port and reads it back through a select/data read port. Slot-side inputs report a device being added (hot or at boot), an unplug request, the attention button and a power fault.

A notification goes out as an MSI-X or MSI request carrying the programmed interrupt message number, or, when neither is enabled, as a level on the INTx output. Every write that reaches slot control is one command. It completes in the cycle it is written, and it may detach the device when the power controller and the power indicator are both switched off.

Top module: `hp_slot_ctrl`

## Requirements
- R1: Register select 0 holds the interrupt message number in bits [VEC_W-1:0], written when byte enable 0 is set. Select 1 holds slot control in bits [15:0] and slot status in bits [31:16]. Each byte is written only when its byte enable is set, and a write with no byte enables changes nothing.
- R2: Status bits 16 (attention button), 17 (power fault), 18 (presence changed) and 19 (command completed) are cleared by writing 1 to them. Raising an event that is already set produces no new notification.
- R3: The event level is true only when hot-plug interrupt enable (control bit 4) is set and some status event is set whose enable (control bits 0..3, in the same order as status bits 16..19) is also set.
- R4: When the level changes, `msg_req` pulses for one cycle with `msg_msix`=1 if MSI-X is enabled, else with `msg_msix`=0 if MSI is enabled, and `msg_vec` equals the message number. With neither enabled, `intx` follows the new level.
- R5: A write that clears status bits changes the level without a message. If MSI and MSI-X are both disabled and the level after the clear is false, `intx` drops.
- R6: An event that arrives while the hot-plug interrupt enable is clear is delivered once a control write sets the enable.
- R7: Writing 1 to control bit 10 toggles the interlock status (status bit 23). Control bit 10 always reads as 0.
- R8: Any write that touches byte 0 or 1 of select 1 sets the command-completed event once the write has been applied.
- R9: A control write that leaves power control (bit 9) at 1 and the power indicator (bits 8:7) at 2'b11 while presence (status bit 22) is set pulses `detach` for one cycle, clears presence and sets the presence-changed event.
- R10: `add_req` or `unplug_req` while the interlock is engaged pulses `busy_err` the next cycle and changes no state.
- R11: A hot add sets presence and raises the button and presence-changed events. An add with `add_cold` set sets presence only. An accepted unplug request and the button input raise the button event, and `pwr_fault` raises the power-fault event.
- R12: Reset clears all enables and events, sets the attention indicator (bits 6:5) to 2'b11 and releases the interlock. If `pop_strap` is 1, it sets the power indicator to 2'b01, power control to 0 and presence to 1. If `pop_strap` is 0, it sets them to 2'b11, 1 and 0.
- R13: When one write clears status bits and writes control in the same cycle, the clear is applied first, so the command-completed event is still set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pop_strap | input | 1 | Slot populated at reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Write register select |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Write byte enables |
| cfg_rd_sel | input | 2 | Read register select |
| cfg_rd_data | output | 32 | Read data |
| msi_en | input | 1 | MSI delivery enabled |
| msix_en | input | 1 | MSI-X delivery enabled |
| add_req | input | 1 | Device added |
| add_cold | input | 1 | Qualifies add as present at boot |
| unplug_req | input | 1 | Unplug request |
| attn_button | input | 1 | Attention button pressed |
| pwr_fault | input | 1 | Power fault detected |
| msg_req | output | 1 | Message request pulse |
| msg_msix | output | 1 | Request is MSI-X (else MSI) |
| msg_vec | output | VEC_W | Message vector |
| intx | output | 1 | Legacy interrupt level |
| detach | output | 1 | Detach device pulse |
| busy_err | output | 1 | Add/unplug rejected by interlock |

## Verification
The notification path is exercised with events raised while the interrupt enable is off, with events raised again while they are still pending, and with status clears under each of the three delivery modes. This separates real level changes from repeated raises and from silent clears. Combined status-clear plus control writes, interlock toggles followed by add and unplug requests, and detach followed by cold and hot adds show the order of operations inside a single cycle. A reference model compares every output and the read-back on each clock.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 2;
  localparam int BE_W     = DATA_W / 8;
  localparam int EVT_N    = 4;
  localparam int CTL_KEEP = 10;           // stored control bits [9:0]

  localparam logic [SEL_W-1:0] SEL_FLAGS = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SLOT  = 2'd1;

  // status event positions (status bits, +16 in the dword)
  localparam int EV_BTN = 0;
  localparam int EV_PF  = 1;
  localparam int EV_PDC = 2;
  localparam int EV_CC  = 3;
  localparam logic [EVT_N-1:0] EVT_SUPPORTED = 4'b1111;

  // control positions
  localparam int C_HPIE = 4;
  localparam int C_AIND = 5;   // 2 bits
  localparam int C_PIND = 7;   // 2 bits
  localparam int C_PCTL = 9;
  localparam int C_LOCK = 10;  // action bit, never stored

  localparam int STS_OFS = 16;
  localparam logic [1:0] IND_ON  = 2'b01;
  localparam logic [1:0] IND_OFF = 2'b11;

  function automatic logic hp_level(input logic [CTL_KEEP-1:0] c,
                                    input logic [EVT_N-1:0] e);
    return c[C_HPIE] & (|(c[EVT_N-1:0] & e & EVT_SUPPORTED));
  endfunction
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pop_strap,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [BE_W-1:0]     wr_be,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                add_req,
  input  logic                add_cold,
  input  logic                unplug_req,
  input  logic                attn_button,
  input  logic                pwr_fault,
  output logic [CTL_KEEP-1:0] ctl_cur,
  output logic [EVT_N-1:0]    evt_mid,
  output logic [CTL_KEEP-1:0] ctl_nxt,
  output logic [EVT_N-1:0]    evt_nxt,
  output logic                sts_wr,
  output logic [VEC_W-1:0]    vec,
  output logic                detach,
  output logic                busy_err
);
  logic [CTL_KEEP-1:0] ctl_q, ctl_n;
  logic [EVT_N-1:0]    evt_q, evt_n, evt_clr;
  logic                pres_q, pres_n, lock_q, lock_n;
  logic [VEC_W-1:0]    vec_q, vec_n;
  logic                vec_en, det_n, det_q, busy_n, busy_q;
  logic                slot_wr, ctl_wr;
  logic [CTL_KEEP-1:0] ctl_rst;

  assign slot_wr = wr_en && (wr_sel == SEL_SLOT);
  assign ctl_wr  = slot_wr && (wr_be[0] || wr_be[1]);
  assign sts_wr  = slot_wr && (wr_be[2] || wr_be[3]);
  assign vec_en  = wr_en && (wr_sel == SEL_FLAGS) && wr_be[0];

  always_comb begin
    ctl_rst                 = '0;
    ctl_rst[C_AIND +: 2]    = IND_OFF;
    ctl_rst[C_PIND +: 2]    = pop_strap ? IND_ON : IND_OFF;
    ctl_rst[C_PCTL]         = ~pop_strap;
  end

  always_comb begin
    vec_n = wr_data[VEC_W-1:0];

    // step 1: write-1-to-clear of status events
    evt_clr = evt_q;
    if (sts_wr && wr_be[2]) evt_clr = evt_q & ~wr_data[STS_OFS +: EVT_N];

    // step 2: control bytes
    ctl_n = ctl_q;
    if (ctl_wr && wr_be[0]) ctl_n[7:0] = wr_data[7:0];
    if (ctl_wr && wr_be[1]) ctl_n[CTL_KEEP-1:8] = wr_data[CTL_KEEP-1:8];

    // step 3: control actions
    lock_n = lock_q;
    if (ctl_wr && wr_be[1] && wr_data[C_LOCK]) lock_n = ~lock_q;
    det_n  = ctl_wr && pres_q && ctl_n[C_PCTL] && (ctl_n[C_PIND +: 2] == IND_OFF);
    pres_n = pres_q;
    evt_n  = evt_clr;
    if (det_n) begin
      pres_n         = 1'b0;
      evt_n[EV_PDC]  = 1'b1;
    end

    // step 4: slot-side events
    busy_n = (add_req || unplug_req) && lock_q;
    if (add_req && !lock_q) begin
      pres_n = 1'b1;
      if (!add_cold) begin
        evt_n[EV_BTN] = 1'b1;
        evt_n[EV_PDC] = 1'b1;
      end
    end
    if (unplug_req && !lock_q) evt_n[EV_BTN] = 1'b1;
    if (attn_button)           evt_n[EV_BTN] = 1'b1;
    if (pwr_fault)             evt_n[EV_PF]  = 1'b1;

    // step 5: command completes
    if (ctl_wr) evt_n[EV_CC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= ctl_rst;
      evt_q  <= '0;
      pres_q <= pop_strap;
      lock_q <= 1'b0;
      det_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      evt_q  <= evt_n;
      pres_q <= pres_n;
      lock_q <= lock_n;
      det_q  <= det_n;
      busy_q <= busy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_n;
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_FLAGS) begin
      rd_data[VEC_W-1:0] = vec_q;
    end else if (rd_sel == SEL_SLOT) begin
      rd_data[CTL_KEEP-1:0]          = ctl_q;
      rd_data[STS_OFS +: EVT_N]      = evt_q;
      rd_data[STS_OFS + 6]           = pres_q;
      rd_data[STS_OFS + 7]           = lock_q;
    end
  end

  assign ctl_cur  = ctl_q;
  assign evt_mid  = evt_clr;
  assign ctl_nxt  = ctl_n;
  assign evt_nxt  = evt_n;
  assign vec      = vec_q;
  assign detach   = det_q;
  assign busy_err = busy_q;

  // R7
  lock_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_be[1] && wr_data[C_LOCK]) |=> (lock_q != $past(lock_q)));
  // R8
  cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> evt_q[EV_CC]);
  // R9
  detach_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |-> evt_q[EV_PDC]);
  // R10
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $past(lock_q));
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTL_KEEP-1:0] ctl_cur,
  input  logic [EVT_N-1:0]    evt_mid,
  input  logic [CTL_KEEP-1:0] ctl_nxt,
  input  logic [EVT_N-1:0]    evt_nxt,
  input  logic                sts_wr,
  input  logic                msi_en,
  input  logic                msix_en,
  input  logic [VEC_W-1:0]    vec,
  output logic                msg_req,
  output logic                msg_msix,
  output logic [VEC_W-1:0]    msg_vec,
  output logic                intx
);
  logic lvl_mid, lvl_nxt, lvl_chg, msi_any;
  logic req_n, req_q, msix_q, intx_n, intx_q;
  logic [VEC_W-1:0] vec_q;

  assign lvl_mid = hp_level(ctl_cur, evt_mid);
  assign lvl_nxt = hp_level(ctl_nxt, evt_nxt);
  assign lvl_chg = lvl_mid != lvl_nxt;
  assign msi_any = msi_en || msix_en;
  assign req_n   = lvl_chg && msi_any;

  always_comb begin
    intx_n = intx_q;
    if (sts_wr && !msi_any && !lvl_mid) intx_n = 1'b0;
    if (lvl_chg && !msi_any)            intx_n = lvl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      intx_q <= 1'b0;
    end else begin
      req_q  <= req_n;
      intx_q <= intx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msix_q <= 1'b0;
      vec_q  <= '0;
    end else if (req_n) begin
      msix_q <= msix_en;
      vec_q  <= vec;
    end
  end

  assign msg_req  = req_q;
  assign msg_msix = msix_q;
  assign msg_vec  = vec_q;
  assign intx     = intx_q;

  // R4
  msg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> $past(msi_en || msix_en));
  // R5
  intx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !msi_any && !lvl_nxt) |=> !intx);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_strap,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [31:0]       cfg_wr_data,
  input  logic [3:0]        cfg_wr_be,
  input  logic [1:0]        cfg_rd_sel,
  output logic [31:0]       cfg_rd_data,
  input  logic              msi_en,
  input  logic              msix_en,
  input  logic              add_req,
  input  logic              add_cold,
  input  logic              unplug_req,
  input  logic              attn_button,
  input  logic              pwr_fault,
  output logic              msg_req,
  output logic              msg_msix,
  output logic [VEC_W-1:0]  msg_vec,
  output logic              intx,
  output logic              detach,
  output logic              busy_err
);
  logic [CTL_KEEP-1:0] ctl_cur, ctl_nxt;
  logic [EVT_N-1:0]    evt_mid, evt_nxt;
  logic                sts_wr;
  logic [VEC_W-1:0]    vec;

  hp_slot_regs #(.VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .pop_strap(pop_strap),
    .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data), .wr_be(cfg_wr_be),
    .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
    .add_req(add_req), .add_cold(add_cold), .unplug_req(unplug_req),
    .attn_button(attn_button), .pwr_fault(pwr_fault),
    .ctl_cur(ctl_cur), .evt_mid(evt_mid), .ctl_nxt(ctl_nxt), .evt_nxt(evt_nxt),
    .sts_wr(sts_wr), .vec(vec), .detach(detach), .busy_err(busy_err)
  );

  hp_slot_notify #(.VEC_W(VEC_W)) u_notify (
    .clk(clk), .rst_n(rst_n),
    .ctl_cur(ctl_cur), .evt_mid(evt_mid), .ctl_nxt(ctl_nxt), .evt_nxt(evt_nxt),
    .sts_wr(sts_wr), .msi_en(msi_en), .msix_en(msix_en), .vec(vec),
    .msg_req(msg_req), .msg_msix(msg_msix), .msg_vec(msg_vec), .intx(intx)
  );
endmodule

// File: tb/hp_slot_ctrl_test.sv
module hp_slot_ctrl_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pop_strap, wr_en, msi_en, msix_en;
  logic add_req, add_cold, unplug_req, button, pfault;
  logic [1:0] wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic [3:0] wr_be;
  logic msg_req, msg_msix, intx, detach, busy_err;
  logic [4:0] msg_vec;

  hp_slot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pop_strap(pop_strap),
    .cfg_wr_en(wr_en), .cfg_wr_sel(wr_sel), .cfg_wr_data(wr_data), .cfg_wr_be(wr_be),
    .cfg_rd_sel(rd_sel), .cfg_rd_data(rd_data), .msi_en(msi_en), .msix_en(msix_en),
    .add_req(add_req), .add_cold(add_cold), .unplug_req(unplug_req),
    .attn_button(button), .pwr_fault(pfault),
    .msg_req(msg_req), .msg_msix(msg_msix), .msg_vec(msg_vec), .intx(intx),
    .detach(detach), .busy_err(busy_err)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // behavioural reference state
  bit [9:0] m_ctl;
  bit [3:0] m_evt;
  bit m_pres, m_lock, m_req, m_x, m_intx, m_det, m_busy;
  bit [4:0] m_vec, m_rv;

  function automatic bit level(bit [9:0] c, bit [3:0] e);
    return c[4] && ((c[3:0] & e) != 4'b0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl  = {~pop_strap, (pop_strap ? 2'b01 : 2'b11), 2'b11, 5'b0};
    m_evt  = 0; m_pres = pop_strap; m_lock = 0; m_vec = 0;
    m_req = 0; m_x = 0; m_rv = 0; m_intx = 0; m_det = 0; m_busy = 0;
  endtask

  task automatic model_step();
    bit swr, cwr, mid, fin, any_msi, lock_at_start;
    bit [3:0] e;
    bit [9:0] c;
    swr = wr_en && wr_sel == 2'd1 && (wr_be[2] || wr_be[3]);
    cwr = wr_en && wr_sel == 2'd1 && (wr_be[0] || wr_be[1]);
    any_msi = msi_en || msix_en;
    lock_at_start = m_lock;
    e = m_evt;
    if (swr && wr_be[2]) e = e & ~wr_data[19:16];
    mid = level(m_ctl, e);
    c = m_ctl;
    if (cwr && wr_be[0]) c[7:0] = wr_data[7:0];
    if (cwr && wr_be[1]) c[9:8] = wr_data[9:8];
    if (cwr && wr_be[1] && wr_data[10]) m_lock = !m_lock;
    m_det = cwr && m_pres && c[9] && c[8:7] == 2'b11;
    if (m_det) begin m_pres = 0; e[2] = 1; end
    m_busy = (add_req || unplug_req) && lock_at_start;
    if (add_req && !lock_at_start) begin
      m_pres = 1;
      if (!add_cold) e = e | 4'b0101;
    end
    if ((unplug_req && !lock_at_start) || button) e[0] = 1;
    if (pfault) e[1] = 1;
    if (cwr) e[3] = 1;
    fin = level(c, e);
    m_req = (fin != mid) && any_msi;
    if (m_req) begin m_x = msix_en; m_rv = m_vec; end
    if (swr && !any_msi && !mid) m_intx = 0;
    if (fin != mid && !any_msi) m_intx = fin;
    if (wr_en && wr_sel == 2'd0 && wr_be[0]) m_vec = wr_data[4:0];
    m_ctl = c;
    m_evt = e;
  endtask

  function automatic bit [31:0] model_rd(bit [1:0] s);
    if (s == 2'd0) return {27'b0, m_vec};
    if (s == 2'd1) return {8'h00, m_lock, m_pres, 2'b00, m_evt, 6'b0, m_ctl};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R4 msg_req", msg_req, m_req);
      if (m_req) begin
        check("R4 msg_msix", msg_msix, m_x);
        check("R4 msg_vec", msg_vec, m_rv);
      end
      check("R5 intx", intx, m_intx);
      check("R9 detach", detach, m_det);
      check("R10 busy_err", busy_err, m_busy);
      check("R1 readback", rd_data, model_rd(rd_sel));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr(input bit [1:0] s, input bit [31:0] d, input bit [3:0] b);
    wr_en = 1; wr_sel = s; wr_data = d; wr_be = b;
    cyc();
    wr_en = 0; wr_be = 0; wr_data = 0;
  endtask

  task automatic pulse(input int which, input bit cold);
    case (which)
      0: button = 1;
      1: pfault = 1;
      2: begin add_req = 1; add_cold = cold; end
      default: unplug_req = 1;
    endcase
    cyc();
    button = 0; pfault = 0; add_req = 0; add_cold = 0; unplug_req = 0;
  endtask

  task automatic do_reset(input bit pop);
    pop_strap = pop; rst_n = 0;
    repeat (2) cyc();
    rst_n = 1;
    cyc();
  endtask

  initial begin
    wr_en = 0; wr_sel = 0; wr_data = 0; wr_be = 0; rd_sel = 1;
    msi_en = 0; msix_en = 0;
    add_req = 0; add_cold = 0; unplug_req = 0; button = 0; pfault = 0;
    do_reset(1'b1);
    check("R12 reset populated", rd_data, 32'h0040_00E0);

    // R1 message number and byte enables
    rd_sel = 0;
    wr(2'd0, 32'h13, 4'b0001);
    check("R1 vector written", rd_data, 32'h13);
    wr(2'd0, 32'h05, 4'b0000);
    check("R1 no byte enable", rd_data, 32'h13);
    rd_sel = 1;

    // R6 event while disabled, delivered when enabled
    pulse(0, 0);
    check("R6 masked intx", intx, 0);
    check("R2 button bit", rd_data[16], 1);
    wr(2'd1, 32'h71, 4'b0001);
    check("R6 delivered", intx, 1);
    check("R8 cc after ctl write", rd_data[19], 1);
    check("R3 level needs enable", rd_data[4], 1);

    // R2 re-raise pending event
    pulse(0, 0);
    check("R2 no new notification", intx, 1);

    // R5 clear with INTx
    wr(2'd1, 32'h0001_0000, 4'b0100);
    check("R5 intx dropped", intx, 0);
    check("R2 w1c clears only written bit", rd_data[19:16], 4'b1000);

    // R4 MSI-X
    msix_en = 1;
    pulse(0, 0);
    check("R4 msix req", {msg_req, msg_msix, msg_vec}, {2'b11, 5'h13});
    cyc();
    check("R4 single pulse", msg_req, 0);
    wr(2'd1, 32'h0001_0000, 4'b0100);
    check("R5 silent clear", msg_req, 0);

    // R4 MSI with power fault
    msix_en = 0; msi_en = 1;
    wr(2'd1, 32'h73, 4'b0001);
    pulse(1, 0);
    check("R4 msi req", {msg_req, msg_msix}, 2'b10);
    wr(2'd1, 32'h0002_0000, 4'b0100);

    // R13 clear and control in one write
    wr(2'd1, 32'h0008_0079, 4'b0101);
    check("R13 cc survives", rd_data[19], 1);
    msi_en = 0;

    // R7 interlock, R10 busy
    wr(2'd1, 32'h0000_0400, 4'b0010);
    check("R7 lock engaged", rd_data[23], 1);
    check("R7 ctl reads zero", rd_data[10], 0);
    pulse(2, 0);
    check("R10 add busy", busy_err, 1);
    pulse(3, 0);
    check("R10 unplug busy", busy_err, 1);
    wr(2'd1, 32'h0000_0400, 4'b0010);
    check("R7 lock released", rd_data[23], 0);

    // R9 detach
    wr(2'd1, 32'h0000_03FF, 4'b0011);
    check("R9 detach pulse", detach, 1);
    check("R9 presence cleared", rd_data[22], 0);
    check("R9 pdc set", rd_data[18], 1);

    // R11 cold add, detach again, hot add, unplug
    wr(2'd1, 32'h000F_0000, 4'b0100);
    pulse(2, 1);
    check("R11 cold add", rd_data[22:16], 7'b1000000);
    wr(2'd1, 32'h0000_03FF, 4'b0011);
    wr(2'd1, 32'h000F_0000, 4'b0100);
    pulse(2, 0);
    check("R11 hot add", rd_data[22:16], 7'b1000101);
    wr(2'd1, 32'h000F_0000, 4'b0100);
    pulse(3, 0);
    check("R11 unplug button", rd_data[16], 1);

    do_reset(1'b0);
    check("R12 reset empty", rd_data, 32'h0000_03E0);
    repeat (3) cyc();
    finish_run();
  end
endmodule